// File: doc/BRIEF.md
# Cross-Packet Payload String Matcher

This block scans the payload bytes of network packets for a small set of programmable byte strings of 1 to 16 bytes and reports every hit to a downstream decision unit. Strings of different lengths are searched at the same time. Each accepted byte is shifted into a 16-byte search window. Every loaded pattern compares its own length's worth of the newest window bytes on the same cycle, and the hits are reported one cycle later.

A string can start near the end of one packet and finish at the start of the next packet of the same connection. To find it, the block keeps a short per-connection store of the most recent payload bytes. The store holds 15 bytes, one fewer than the longest pattern. At the first byte of a packet, the store for that connection is preloaded into the window, with marks that say which bytes are real and which came from an earlier packet. At the end of a packet, the newest 15 bytes go back into the store. A hit whose first byte came from the preloaded bytes is flagged as spanning. Only bytes of packets that the header filter has passed are searched or retained.

Patterns are written byte by byte through a load port. Each of the eight slots has its own length and enable bit.

Top module: `xpkt_string_scan`

## Requirements
- R1: After synchronous reset, `hit_valid` is 0, `pl_ready` is 1, every pattern slot is disabled, and every connection's retained-byte count is zero, so the first packet of each connection sees no earlier bytes.
- R2: A payload byte is accepted when `pl_valid`, `pl_ready` and `pl_allow` are all 1. On the cycle after an accepted byte that completes one or more enabled patterns, `hit_valid` is 1, `hit_slots` has bit i set for each matching slot i, and `hit_conn` equals that byte's `pl_conn`. Otherwise `hit_valid` and `hit_slots` are 0.
- R3: Slots of different lengths are compared in parallel. When several slots match on the same byte, all of their bits are set in the same cycle.
- R4: A connection's retained bytes are the most recent up to 15 accepted payload bytes of that connection. A pattern whose first byte lies in those retained bytes and whose last byte lies in the current packet is reported, with its `hit_span` bit set.
- R5: Retained bytes belong to one connection only. A packet on another connection between two packets neither erases nor lends its bytes, and the first byte of a packet never matches against bytes left in the window by a different connection.
- R6: Bytes presented with `pl_allow` = 0 cause no hit, do not change the retained bytes of their connection, and do not cause the write-back stall of R9.
- R7: A load write (`ld_en` = 1) stores `ld_data` as byte `ld_byte` of slot `ld_slot`, where byte 0 is the first byte of the string. It also sets the slot's length to `ld_len` and its enable to `ld_valid`. A slot whose enable is 0 never matches. A slot matches only with a length from 1 to 16.
- R8: Window positions not holding a real byte never take part in a match. This covers a fresh connection, a packet shorter than the pattern, and a retained store holding fewer bytes than the pattern needs.
- R9: `pl_ready` is 0 for exactly the one cycle after an accepted byte with `pl_eop` = 1, and 1 at every other time.
- R10: A match lying entirely inside the current packet has its `hit_span` bit clear, even when retained bytes from the previous packet are present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pl_valid | input | 1 | Payload byte present |
| pl_ready | output | 1 | Block can take a byte; low during write-back |
| pl_data | input | 8 | Payload byte |
| pl_sop | input | 1 | First byte of a packet |
| pl_eop | input | 1 | Last byte of a packet |
| pl_allow | input | 1 | Packet passed the header filter |
| pl_conn | input | 2 | Connection index of the byte |
| ld_en | input | 1 | Pattern load write strobe |
| ld_slot | input | 3 | Slot written |
| ld_byte | input | 4 | Byte position inside the string (0 = first) |
| ld_data | input | 8 | Pattern byte value |
| ld_len | input | 5 | Pattern length, 1 to 16 |
| ld_valid | input | 1 | Slot enable |
| hit_valid | output | 1 | A match event is present |
| hit_slots | output | 8 | One bit per matching slot |
| hit_span | output | 8 | Per-slot flag: match began in an earlier packet |
| hit_conn | output | 2 | Connection index of the matching byte |

## Verification
The cycle-level properties are checked on every cycle. These are the one-cycle stall after each accepted end of packet and its release, hit events only after an accepted byte, no hit from a disabled slot, and the real-byte marks in the window and in the write-back staying a contiguous run from the newest byte. Whether the right bytes are retained, and whether they are kept apart per connection, shows only through the bench's packet sequences. Those sequences cover a split string found with its span flag, a stale window on another connection failing to match, a 16-byte string completed by a one-byte packet, and filtered-out packets leaving the store unchanged.

// File: rtl/xss_pkg.sv
`timescale 1ns/1ps
package xss_pkg;
    localparam int XS_SLOTS  = 8;
    localparam int XS_MAXLEN = 16;
    localparam int XS_CONNS  = 4;

    typedef enum logic {
        WB_IDLE,
        WB_WRITE
    } wb_state_e;

    typedef struct packed {
        logic hit;
        logic span;
    } slot_res_t;
endpackage

// File: rtl/xss_pattern_bank.sv
`timescale 1ns/1ps
module xss_pattern_bank #(
    parameter int SLOTS  = 8,
    parameter int MAXLEN = 16,
    localparam int SW = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    localparam int BW = (MAXLEN > 1) ? $clog2(MAXLEN) : 1,
    localparam int LW = $clog2(MAXLEN + 1)
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           ld_en,
    input  logic [SW-1:0]                  ld_slot,
    input  logic [BW-1:0]                  ld_byte,
    input  logic [7:0]                     ld_data,
    input  logic [LW-1:0]                  ld_len,
    input  logic                           ld_valid,
    output logic [SLOTS-1:0][MAXLEN-1:0][7:0] pat_bytes,
    output logic [SLOTS-1:0][LW-1:0]       pat_len,
    output logic [SLOTS-1:0]               pat_vld
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pat_bytes <= '0;
            pat_len   <= '0;
            pat_vld   <= '0;
        end else if (ld_en) begin
            pat_bytes[ld_slot][ld_byte] <= ld_data;
            pat_len[ld_slot]            <= ld_len;
            pat_vld[ld_slot]            <= ld_valid;
        end
    end

    // R7: an enabled slot is always given a length the matcher accepts
    p_load_len_r7: assert property (@(posedge clk) disable iff (rst)
        (ld_en && ld_valid) |-> (ld_len != '0 && int'(ld_len) <= MAXLEN));
endmodule

// File: rtl/xss_window.sv
`timescale 1ns/1ps
module xss_window #(
    parameter int MAXLEN = 16,
    localparam int TAILN = MAXLEN - 1,
    localparam int CW = $clog2(MAXLEN)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         take,
    input  logic                         sop,
    input  logic [7:0]                   in_byte,
    input  logic [TAILN-1:0][7:0]        tail_bytes,
    input  logic [CW-1:0]                tail_cnt,
    output logic [MAXLEN-1:0][7:0]       nxt_bytes,
    output logic [MAXLEN-1:0]            nxt_real,
    output logic [MAXLEN-1:0]            nxt_old,
    output logic [TAILN-1:0][7:0]        keep_bytes,
    output logic [TAILN-1:0]             keep_real
);
    // Registered window, newest byte at index 0; only TAILN entries survive
    logic [TAILN-1:0][7:0] cur_bytes;
    logic [TAILN-1:0]      cur_real;
    logic [TAILN-1:0]      cur_old;

    logic [TAILN-1:0][7:0] base_bytes;
    logic [TAILN-1:0]      base_real;
    logic [TAILN-1:0]      base_old;

    // At packet start the connection's retained bytes replace the window
    always_comb begin
        for (int k = 0; k < TAILN; k++) begin
            if (sop) begin
                base_bytes[k] = tail_bytes[k];
                base_real[k]  = (int'(tail_cnt) > k);
                base_old[k]   = (int'(tail_cnt) > k);
            end else begin
                base_bytes[k] = cur_bytes[k];
                base_real[k]  = cur_real[k];
                base_old[k]   = cur_old[k];
            end
        end
    end

    assign nxt_bytes = {base_bytes, in_byte};
    assign nxt_real  = {base_real, 1'b1};
    assign nxt_old   = {base_old, 1'b0};

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_bytes <= '0;
            cur_real  <= '0;
            cur_old   <= '0;
        end else if (take) begin
            cur_bytes <= nxt_bytes[TAILN-1:0];
            cur_real  <= nxt_real[TAILN-1:0];
            cur_old   <= nxt_old[TAILN-1:0];
        end
    end

    assign keep_bytes = cur_bytes;
    assign keep_real  = cur_real;

    // R8: real-byte marks form one run starting at the newest byte
    p_marks_contig_r8: assert property (@(posedge clk) disable iff (rst)
        (cur_real & (cur_real + 1'b1)) == '0);
    // R4: a byte flagged as earlier-packet is always a real byte
    p_old_is_real_r4: assert property (@(posedge clk) disable iff (rst)
        (cur_old & ~cur_real) == '0);
endmodule

// File: rtl/xss_tail_table.sv
`timescale 1ns/1ps
module xss_tail_table #(
    parameter int MAXLEN = 16,
    parameter int CONNS  = 4,
    localparam int TAILN = MAXLEN - 1,
    localparam int CW = $clog2(MAXLEN),
    localparam int NW = (CONNS > 1) ? $clog2(CONNS) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NW-1:0]         rd_conn,
    output logic [TAILN-1:0][7:0] rd_bytes,
    output logic [CW-1:0]         rd_cnt,
    input  logic                  wr_en,
    input  logic [NW-1:0]         wr_conn,
    input  logic [TAILN-1:0][7:0] wr_bytes,
    input  logic [TAILN-1:0]      wr_marks
);
    logic [CONNS-1:0][TAILN-1:0][7:0] store_bytes;
    logic [CONNS-1:0][CW-1:0]         store_cnt;

    assign rd_bytes = store_bytes[rd_conn];
    assign rd_cnt   = store_cnt[rd_conn];

    always_ff @(posedge clk) begin
        if (rst) begin
            store_bytes <= '0;
            store_cnt   <= '0;
        end else if (wr_en) begin
            store_bytes[wr_conn] <= wr_bytes;
            store_cnt[wr_conn]   <= CW'($countones(wr_marks));
        end
    end

    // R8: what is written back is a contiguous run from the newest byte
    p_wb_marks_r8: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> ((wr_marks & (wr_marks + 1'b1)) == '0));
endmodule

// File: rtl/xss_matcher.sv
`timescale 1ns/1ps
module xss_matcher #(
    parameter int SLOTS  = 8,
    parameter int MAXLEN = 16,
    localparam int LW = $clog2(MAXLEN + 1)
) (
    input  logic [MAXLEN-1:0][7:0]            win_bytes,
    input  logic [MAXLEN-1:0]                 win_real,
    input  logic [MAXLEN-1:0]                 win_old,
    input  logic [SLOTS-1:0][MAXLEN-1:0][7:0] pat_bytes,
    input  logic [SLOTS-1:0][LW-1:0]          pat_len,
    input  logic [SLOTS-1:0]                  pat_vld,
    output logic [SLOTS-1:0]                  hits,
    output logic [SLOTS-1:0]                  spans
);
    import xss_pkg::*;

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        slot_res_t res;
        int        plen;
        logic      ok;
        logic      first_old;

        // Window index k (k bytes back) pairs with string byte plen-1-k
        always_comb begin
            plen      = int'(pat_len[s]);
            ok        = pat_vld[s] && (plen >= 1) && (plen <= MAXLEN);
            first_old = 1'b0;
            if (ok) begin
                for (int k = 0; k < MAXLEN; k++) begin
                    if (k < plen) begin
                        if (!win_real[k] || (win_bytes[k] != pat_bytes[s][plen-1-k]))
                            ok = 1'b0;
                        if (k == plen - 1)
                            first_old = win_old[k];
                    end
                end
            end
            res.hit  = ok;
            res.span = ok && first_old;
        end

        assign hits[s]  = res.hit;
        assign spans[s] = res.span;
    end
endmodule

// File: rtl/xpkt_string_scan.sv
`timescale 1ns/1ps
module xpkt_string_scan #(
    parameter int SLOTS  = xss_pkg::XS_SLOTS,
    parameter int MAXLEN = xss_pkg::XS_MAXLEN,
    parameter int CONNS  = xss_pkg::XS_CONNS,
    localparam int SW = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    localparam int BW = (MAXLEN > 1) ? $clog2(MAXLEN) : 1,
    localparam int LW = $clog2(MAXLEN + 1),
    localparam int NW = (CONNS > 1) ? $clog2(CONNS) : 1,
    localparam int CW = $clog2(MAXLEN),
    localparam int TAILN = MAXLEN - 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pl_valid,
    output logic             pl_ready,
    input  logic [7:0]       pl_data,
    input  logic             pl_sop,
    input  logic             pl_eop,
    input  logic             pl_allow,
    input  logic [NW-1:0]    pl_conn,
    input  logic             ld_en,
    input  logic [SW-1:0]    ld_slot,
    input  logic [BW-1:0]    ld_byte,
    input  logic [7:0]       ld_data,
    input  logic [LW-1:0]    ld_len,
    input  logic             ld_valid,
    output logic             hit_valid,
    output logic [SLOTS-1:0] hit_slots,
    output logic [SLOTS-1:0] hit_span,
    output logic [NW-1:0]    hit_conn
);
    import xss_pkg::*;

    wb_state_e st;
    logic [NW-1:0] wb_conn;
    logic take;

    logic [SLOTS-1:0][MAXLEN-1:0][7:0] pat_bytes;
    logic [SLOTS-1:0][LW-1:0]          pat_len;
    logic [SLOTS-1:0]                  pat_vld;

    logic [TAILN-1:0][7:0]  tail_bytes;
    logic [CW-1:0]          tail_cnt;
    logic [MAXLEN-1:0][7:0] nxt_bytes;
    logic [MAXLEN-1:0]      nxt_real;
    logic [MAXLEN-1:0]      nxt_old;
    logic [TAILN-1:0][7:0]  keep_bytes;
    logic [TAILN-1:0]       keep_real;
    logic [SLOTS-1:0]       hits;
    logic [SLOTS-1:0]       spans;

    assign pl_ready = (st == WB_IDLE);
    assign take     = pl_valid && pl_ready && pl_allow;

    xss_pattern_bank #(.SLOTS(SLOTS), .MAXLEN(MAXLEN)) u_bank (
        .clk(clk), .rst(rst),
        .ld_en(ld_en), .ld_slot(ld_slot), .ld_byte(ld_byte),
        .ld_data(ld_data), .ld_len(ld_len), .ld_valid(ld_valid),
        .pat_bytes(pat_bytes), .pat_len(pat_len), .pat_vld(pat_vld)
    );

    xss_tail_table #(.MAXLEN(MAXLEN), .CONNS(CONNS)) u_tail (
        .clk(clk), .rst(rst),
        .rd_conn(pl_conn), .rd_bytes(tail_bytes), .rd_cnt(tail_cnt),
        .wr_en(st == WB_WRITE), .wr_conn(wb_conn),
        .wr_bytes(keep_bytes), .wr_marks(keep_real)
    );

    xss_window #(.MAXLEN(MAXLEN)) u_win (
        .clk(clk), .rst(rst),
        .take(take), .sop(pl_sop), .in_byte(pl_data),
        .tail_bytes(tail_bytes), .tail_cnt(tail_cnt),
        .nxt_bytes(nxt_bytes), .nxt_real(nxt_real), .nxt_old(nxt_old),
        .keep_bytes(keep_bytes), .keep_real(keep_real)
    );

    xss_matcher #(.SLOTS(SLOTS), .MAXLEN(MAXLEN)) u_match (
        .win_bytes(nxt_bytes), .win_real(nxt_real), .win_old(nxt_old),
        .pat_bytes(pat_bytes), .pat_len(pat_len), .pat_vld(pat_vld),
        .hits(hits), .spans(spans)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= WB_IDLE;
            wb_conn   <= '0;
            hit_valid <= 1'b0;
            hit_slots <= '0;
            hit_span  <= '0;
            hit_conn  <= '0;
        end else begin
            case (st)
                WB_IDLE: if (take && pl_eop) begin
                    st      <= WB_WRITE;
                    wb_conn <= pl_conn;
                end
                default: st <= WB_IDLE;
            endcase
            hit_valid <= take && (hits != '0);
            hit_slots <= take ? hits  : '0;
            hit_span  <= take ? spans : '0;
            if (take) hit_conn <= pl_conn;
        end
    end

    // R1: the first cycle after reset is idle and ready
    p_reset_idle_r1: assert property (@(posedge clk)
        $past(rst) |-> (!hit_valid && pl_ready));
    // R9: an accepted end of packet stalls the next cycle
    p_eop_stall_r9: assert property (@(posedge clk) disable iff (rst)
        (take && pl_eop) |=> !pl_ready);
    // R9: the stall never lasts more than one cycle
    p_stall_once_r9: assert property (@(posedge clk) disable iff (rst)
        !pl_ready |=> pl_ready);
    // R2: a hit event follows an accepted byte
    p_hit_after_take_r2: assert property (@(posedge clk) disable iff (rst)
        hit_valid |-> $past(take));
    // R7: only enabled slots produce hits
    p_hit_enabled_r7: assert property (@(posedge clk) disable iff (rst)
        hit_valid |-> ((hit_slots & ~$past(pat_vld)) == '0));
endmodule

// File: tb/xpkt_string_scan_bench.sv
`timescale 1ns/1ps
module xpkt_string_scan_bench;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst;
    logic       pl_valid, pl_ready, pl_sop, pl_eop, pl_allow;
    logic [7:0] pl_data;
    logic [1:0] pl_conn;
    logic       ld_en, ld_valid;
    logic [2:0] ld_slot;
    logic [3:0] ld_byte;
    logic [7:0] ld_data;
    logic [4:0] ld_len;
    logic       hit_valid;
    logic [7:0] hit_slots, hit_span;
    logic [1:0] hit_conn;

    xpkt_string_scan u_xpkt_string_scan (
        .clk(clk), .rst(rst),
        .pl_valid(pl_valid), .pl_ready(pl_ready), .pl_data(pl_data),
        .pl_sop(pl_sop), .pl_eop(pl_eop), .pl_allow(pl_allow), .pl_conn(pl_conn),
        .ld_en(ld_en), .ld_slot(ld_slot), .ld_byte(ld_byte), .ld_data(ld_data),
        .ld_len(ld_len), .ld_valid(ld_valid),
        .hit_valid(hit_valid), .hit_slots(hit_slots), .hit_span(hit_span),
        .hit_conn(hit_conn)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    bit         g_vld  [16];
    logic [7:0] g_hits [16];
    logic [7:0] g_span [16];
    logic [1:0] g_conn [16];
    int         g_len;
    logic       g_rdy0, g_rdy1;

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic load_pat(int slot, string s, bit en);
        for (int i = 0; i < s.len(); i++) begin
            @(negedge clk);
            ld_en    = 1'b1;
            ld_slot  = 3'(slot);
            ld_byte  = 4'(i);
            ld_data  = s[i];
            ld_len   = 5'(s.len());
            ld_valid = en;
        end
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    // Sends one packet; records the result seen after each byte
    task automatic pkt(int conn, bit allow, string s);
        g_len = s.len();
        for (int i = 0; i < g_len; i++) begin
            while (!pl_ready) @(negedge clk);
            pl_valid = 1'b1;
            pl_data  = s[i];
            pl_sop   = (i == 0);
            pl_eop   = (i == g_len - 1);
            pl_allow = allow;
            pl_conn  = 2'(conn);
            @(negedge clk);
            pl_valid  = 1'b0;
            g_vld[i]  = hit_valid;
            g_hits[i] = hit_slots;
            g_span[i] = hit_span;
            g_conn[i] = hit_conn;
        end
        g_rdy0 = pl_ready;
        @(negedge clk);
        g_rdy1 = pl_ready;
    endtask

    task automatic expect_at(int i, logic [7:0] h, logic [7:0] sp, int conn, string req);
        check(req, $sformatf("hit_valid at byte %0d", i), 32'(g_vld[i]), 32'(h != 8'h00));
        check(req, $sformatf("hit_slots at byte %0d", i), 32'(g_hits[i]), 32'(h));
        check(req, $sformatf("hit_span at byte %0d", i), 32'(g_span[i]), 32'(sp));
        check(req, $sformatf("hit_conn at byte %0d", i), 32'(g_conn[i]), 32'(conn));
    endtask

    task automatic expect_quiet(logic [15:0] skip, string req);
        for (int i = 0; i < g_len; i++)
            if (!skip[i]) check(req, $sformatf("no hit at byte %0d", i), 32'(g_vld[i]), 32'd0);
    endtask

    task automatic t_reset();
        check("R1", "hit_valid after reset", 32'(hit_valid), 32'd0);
        check("R1", "pl_ready after reset", 32'(pl_ready), 32'd1);
    endtask

    task automatic t_unloaded();
        // R1: all slots disabled after reset, so even this text finds nothing
        pkt(3, 1'b1, "ABCDQQ");
        expect_quiet(16'h0000, "R1");
    endtask

    task automatic t_single();
        // R2 R3: "ABCD", "CD" and "D" all end on byte 5
        pkt(0, 1'b1, "xxABCDyy");
        expect_at(5, 8'h0B, 8'h00, 0, "R3");
        expect_quiet(16'h0020, "R2");
        check("R9", "ready in cycle after eop", 32'(g_rdy0), 32'd0);
        check("R9", "ready one cycle later", 32'(g_rdy1), 32'd1);
    endtask

    task automatic t_other_conn();
        pkt(0, 1'b1, "xxAB");
        expect_quiet(16'h0000, "R2");
        // R5 R8: stale "AB" in the window must not complete "ABCD" on conn 2
        pkt(2, 1'b1, "CD");
        expect_at(1, 8'h0A, 8'h00, 2, "R5");
        expect_quiet(16'h0002, "R8");
    endtask

    task automatic t_span();
        // R4 R10: "AB" retained on conn 0 completes across the boundary
        pkt(0, 1'b1, "CDz");
        expect_at(1, 8'h0B, 8'h01, 0, "R4");
        expect_quiet(16'h0002, "R10");
    endtask

    task automatic t_filtered();
        pkt(1, 1'b1, "zzA");
        expect_quiet(16'h0000, "R8");
        pkt(1, 1'b0, "ABCD");
        expect_quiet(16'h0000, "R6");
        check("R6", "no stall after filtered eop", 32'(g_rdy0), 32'd1);
        // R6: retained bytes still end in "A" from the allowed packet
        pkt(1, 1'b1, "BCD");
        expect_at(2, 8'h0B, 8'h01, 1, "R6");
        expect_quiet(16'h0004, "R6");
    endtask

    task automatic t_longest();
        pkt(2, 1'b1, "q0123456789abcde");
        expect_quiet(16'h0000, "R8");
        // R4: all 15 retained bytes plus one new byte make the 16-byte string
        pkt(2, 1'b1, "f");
        expect_at(0, 8'h04, 8'h04, 2, "R4");
        pkt(2, 1'b1, "0123456789abcdef");
        expect_at(15, 8'h04, 8'h00, 2, "R10");
        expect_quiet(16'h8000, "R10");
    endtask

    task automatic t_enable();
        pkt(3, 1'b1, "QQ");
        expect_quiet(16'h0000, "R7");
        load_pat(4, "QQ", 1'b1);
        pkt(3, 1'b1, "QQ");
        expect_at(0, 8'h10, 8'h10, 3, "R7");
        expect_at(1, 8'h10, 8'h00, 3, "R7");
    endtask

    initial begin
        rst = 1'b1;
        pl_valid = 1'b0; pl_data = '0; pl_sop = 1'b0; pl_eop = 1'b0;
        pl_allow = 1'b0; pl_conn = '0;
        ld_en = 1'b0; ld_slot = '0; ld_byte = '0; ld_data = '0; ld_len = '0; ld_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_unloaded();
        load_pat(0, "ABCD", 1'b1);
        load_pat(1, "CD", 1'b1);
        load_pat(2, "0123456789abcdef", 1'b1);
        load_pat(3, "D", 1'b1);
        load_pat(4, "QQ", 1'b0);
        t_single();
        t_other_conn();
        t_span();
        t_filtered();
        t_longest();
        t_enable();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule